// File: doc/BRIEF.md
# Duty-Cycle Line Symbol Decoder

This block receives a single-wire serial line whose symbols are told apart by how long the line stays high within each symbol period, not by a shared bit clock. Every symbol that the transmitter drives starts with a rising edge and ends low. The decoder therefore treats each rising edge as the start of a new period. It counts the high samples and the total samples between two rising edges, and it classifies the period from the ratio of the two. It needs no baud-rate setting, and two neighbouring symbols may use very different rates.

The input is first passed through a two-flop synchronizer and then sampled on a fast local clock. When the next rising edge closes a symbol, the decoder reports that symbol as a data zero, a data one or a delimiter. The report is a code with a one-cycle valid strobe. A symbol that fits none of the windows gets a separate one-cycle error strobe, which a frame assembler can treat as a framing fault. When the line stays low for longer than the longest legal period, the decoder reports a line-idle symbol. The measured period is output with each report, so a later stage can time a reply pulse against it. The period limits are parameters expressed in local clock cycles. Their defaults are derived from the local clock frequency for symbol rates of 300 Hz to 19.2 kHz, with a margin on each side.

Top module: `duty_symbol_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, `sym_valid`, `sym_err` and `sym_period` are 0. After reset, the line counts as already idle, so holding it low after reset produces no report.
- R2: A closed period P (in samples, with MIN_PERIOD ≤ P ≤ MAX_PERIOD) that has H high samples and satisfies 3·P ≤ 16·H ≤ 5·P is reported with `sym_valid` and `sym_code` = 2'b00 (data zero).
- R3: A closed period with 11·P ≤ 16·H ≤ 13·P is reported with `sym_valid` and `sym_code` = 2'b01 (data one).
- R4: A closed period with 7·P ≤ 16·H ≤ 9·P is reported with `sym_valid` and `sym_code` = 2'b10 (delimiter).
- R5: A closed period of legal length whose high time falls outside all three windows raises `sym_err` for one cycle, and no valid strobe is given for it.
- R6: A period runs from one synchronized rising edge to the next. Each period is judged on its own, whatever the length of its neighbours. With every data, delimiter or error report, `sym_period` carries P, saturated at MAX_PERIOD+1.
- R7: A closed period with P < MIN_PERIOD is reported through `sym_err`, whatever its duty cycle.
- R8: A closed period with P > MAX_PERIOD (for example, a line held high too long) is reported through `sym_err`.
- R9: When the line has been low for MAX_PERIOD consecutive samples, the decoder gives one `sym_valid` with `sym_code` = 2'b11 (line idle) and `sym_period` = MAX_PERIOD. The open symbol is discarded without a report, and no further idle report follows until the line goes high again.
- R10: The first rising edge after reset or after an idle report opens a period but produces no report.
- R11: `sym_valid` and `sym_err` are never high together, and each report lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Recovered serial line, asynchronous to clk |
| sym_valid | output | 1 | One-cycle strobe: a symbol was classified |
| sym_code | output | 2 | 00 zero, 01 one, 10 delimiter, 11 line idle |
| sym_err | output | 1 | One-cycle strobe: invalid symbol (framing fault) |
| sym_period | output | PW | Measured period in samples for the current report |

## Verification
On every cycle, the embedded properties check that the two strobes are exclusive and last one cycle. They also check that a data report comes only after a rising edge that closed an open period, and that its period lies within the legal range. Finally, they check that an idle report comes only while the line is low and carries the idle limit. Whether a given high time lands in the right window, including the exact boundary counts of each window and of the period limits, can only be shown by the bench scenarios. The same holds for dropping the open symbol at an idle timeout and for suppressing the first report after idle. The bench drives exact sample counts and compares each report against a model of the windows.

// File: rtl/duty_symbol_decoder.sv
module duty_symbol_decoder #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int MIN_PERIOD = (CLK_HZ / 19_200) * 15 / 16,
  parameter int MAX_PERIOD = (CLK_HZ / 300) * 17 / 16,
  localparam int SAT = MAX_PERIOD + 1,
  localparam int PW  = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_in,
  output logic          sym_valid,
  output logic [1:0]    sym_code,
  output logic          sym_err,
  output logic [PW-1:0] sym_period
);
  localparam int CW = PW + 5;
  localparam logic [1:0] C_ZERO = 2'b00, C_ONE = 2'b01, C_DELIM = 2'b10, C_IDLE = 2'b11;
  localparam logic [PW-1:0] P_MIN = PW'(MIN_PERIOD);
  localparam logic [PW-1:0] P_MAX = PW'(MAX_PERIOD);
  localparam logic [PW-1:0] P_SAT = PW'(SAT);

  logic          sync1, lvl, lvl_d, active;
  logic [PW-1:0] period_cnt, high_cnt, low_cnt;

  wire rise = lvl & ~lvl_d;

  wire [CW-1:0] pe  = CW'(period_cnt);
  wire [CW-1:0] h16 = CW'(high_cnt) << 4;

  wire in_zero  = (h16 >= pe * 3)  && (h16 <= pe * 5);
  wire in_delim = (h16 >= pe * 7)  && (h16 <= pe * 9);
  wire in_one   = (h16 >= pe * 11) && (h16 <= pe * 13);
  wire per_ok   = (period_cnt >= P_MIN) && (period_cnt <= P_MAX);
  wire sym_ok   = per_ok && (in_zero || in_one || in_delim);

  logic [1:0] kind;
  always_comb begin
    if (in_one)        kind = C_ONE;
    else if (in_delim) kind = C_DELIM;
    else               kind = C_ZERO;
  end

  wire idle_hit = !lvl && active && (low_cnt == P_MAX - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1      <= 1'b0;
      lvl        <= 1'b0;
      lvl_d      <= 1'b0;
      active     <= 1'b0;
      period_cnt <= '0;
      high_cnt   <= '0;
      low_cnt    <= P_MAX;
      sym_valid  <= 1'b0;
      sym_err    <= 1'b0;
      sym_code   <= C_ZERO;
      sym_period <= '0;
    end else begin
      sync1     <= line_in;
      lvl       <= sync1;
      lvl_d     <= lvl;
      sym_valid <= 1'b0;
      sym_err   <= 1'b0;
      if (rise) begin
        active     <= 1'b1;
        period_cnt <= PW'(1);
        high_cnt   <= PW'(1);
        low_cnt    <= '0;
        if (active) begin
          sym_period <= period_cnt;
          if (sym_ok) begin
            sym_valid <= 1'b1;
            sym_code  <= kind;
          end else begin
            sym_err <= 1'b1;
          end
        end
      end else begin
        if (period_cnt != P_SAT) period_cnt <= period_cnt + 1'b1;
        if (lvl && high_cnt != P_SAT) high_cnt <= high_cnt + 1'b1;
        if (lvl) low_cnt <= '0;
        else if (low_cnt != P_MAX) low_cnt <= low_cnt + 1'b1;
        if (idle_hit) begin
          active     <= 1'b0;
          sym_valid  <= 1'b1;
          sym_code   <= C_IDLE;
          sym_period <= P_MAX;
        end
      end
    end
  end

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sym_valid && sym_err));

  p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid || sym_err) |=> !(sym_valid || sym_err));

  p_data_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_code != C_IDLE) |-> (sym_period >= P_MIN && sym_period <= P_MAX));

  p_data_after_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_code != C_IDLE) |-> $past(rise && active));

  p_err_after_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_err |-> $past(rise && active));

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_code == C_IDLE) |-> ($past(!lvl) && sym_period == P_MAX && !active));
endmodule

// File: tb/duty_symbol_decoder_test.sv
module duty_symbol_decoder_test;
  localparam int MINP = 40;
  localparam int MAXP = 600;

  logic clk = 1'b0, rst_n = 1'b0, line = 1'b0;
  always #4 clk = ~clk;

  logic sym_valid, sym_err;
  logic [1:0] sym_code;
  logic [$clog2(MAXP + 2)-1:0] sym_period;

  duty_symbol_decoder #(.MIN_PERIOD(MINP), .MAX_PERIOD(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line),
    .sym_valid(sym_valid), .sym_code(sym_code), .sym_err(sym_err), .sym_period(sym_period));

  int checks = 0, fails = 0;
  int ek [0:1023];
  int ep [0:1023];
  string et [0:1023];
  int wr = 0, rd = 0;
  int ph = 0, pl = 0;
  bit pend = 0;

  function automatic int kind_of(int h, int p);
    if (p < MINP || p > MAXP) return 4;
    if (16*h >= 3*p && 16*h <= 5*p) return 0;
    if (16*h >= 11*p && 16*h <= 13*p) return 1;
    if (16*h >= 7*p && 16*h <= 9*p) return 2;
    return 4;
  endfunction

  function automatic string tag_of(int h, int p);
    int k;
    if (p < MINP) return "R7";
    if (p > MAXP) return "R8";
    k = kind_of(h, p);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic push(int k, int p, string t);
    ek[wr] = k; ep[wr] = p; et[wr] = t; wr++;
  endtask

  task automatic stay_low(int n);
    if (pend && pl + n >= MAXP) begin
      push(3, MAXP, "R9");
      pend = 0;
    end else if (pend) pl += n;
    line = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int h, int l);
    int p;
    if (pend) begin
      p = ph + pl;
      push(kind_of(ph, p), (p > MAXP + 1) ? MAXP + 1 : p, tag_of(ph, p));
    end
    line = 1'b1;
    repeat (h) @(negedge clk);
    ph = h; pl = 0; pend = 1;
    stay_low(l);
  endtask

  always @(negedge clk) begin
    int got;
    if (rst_n && (sym_valid || sym_err)) begin
      got = sym_err ? 4 : int'(sym_code);
      checks++;
      if (rd >= wr) begin
        fails++;
        $display("FAIL R10 unexpected report: got kind %0d period %0d, expected none", got, sym_period);
      end else begin
        if (got != ek[rd] || int'(sym_period) != ep[rd]) begin
          fails++;
          $display("FAIL %s/R6 report %0d: got kind %0d period %0d, expected kind %0d period %0d",
                   et[rd], rd, got, sym_period, ek[rd], ep[rd]);
        end
        rd++;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, got no end, expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    checks++;
    if (sym_valid !== 1'b0 || sym_err !== 1'b0 || sym_period !== '0) begin
      fails++;
      $display("FAIL R1 reset state: got v=%b e=%b per=%0d, expected 0 0 0", sym_valid, sym_err, sym_period);
    end
    rst_n = 1'b1;
    repeat (MAXP + 50) @(negedge clk);
    checks++;
    if (sym_valid !== 1'b0 || sym_err !== 1'b0 || sym_period !== '0) begin
      fails++;
      $display("FAIL R1 after reset: got v=%b e=%b per=%0d, expected 0 0 0", sym_valid, sym_err, sym_period);
    end

    send(32, 32);
    send(12, 52); send(11, 53); send(20, 44); send(21, 43);
    send(44, 20); send(43, 21); send(52, 12); send(53, 11);
    send(28, 36); send(27, 37); send(36, 28); send(37, 27);
    send(12, 36); send(200, 200); send(3, 9);
    send(10, 30); send(10, 20); send(5, 34);
    send(450, 150); send(610, 10);
    send(32, 32); stay_low(64);
    send(8, 8);
    send(32, 32); stay_low(MAXP);
    stay_low(MAXP);
    send(48, 16);
    send(16, 48);

    for (int i = 0; i < 120; i++) begin
      int p, h, nom, sel;
      p = MINP - 5 + int'($urandom % (MAXP - MINP + 11));
      sel = int'($urandom % 4);
      nom = (sel == 0) ? 4 : (sel == 1) ? 12 : 8;
      if (sel == 3) h = 1 + int'($urandom % (p - 1));
      else h = nom * p / 16 + int'($urandom % (p / 8 + 1)) - p / 16;
      if (h < 1) h = 1;
      if (h > p - 1) h = p - 1;
      send(h, p - h);
      if (i % 25 == 24) stay_low(MAXP + int'($urandom % 50));
    end
    stay_low(MAXP + 10);
    repeat (20) @(negedge clk);

    checks++;
    if (rd != wr) begin
      fails++;
      $display("FAIL R9/R6 reports seen: got %0d, expected %0d", rd, wr);
    end
    finish_run();
  end
endmodule